// File: doc/BRIEF.md
# SDRAM Read Sequencer with Early Precharge

This block drives the command bus of one SDRAM bank for reads. A request carries a bank, row, column and the number of data elements wanted. The block opens the row with ACTIVE and, after a fixed row-to-column delay, issues READ. It then closes the row with an explicit PRECHARGE placed at the earliest slot that still delivers every wanted element. That slot is CAS latency minus one cycles before the edge that carries the last wanted element. The PRECHARGE therefore cuts a long burst short, ends a full-page burst, or ends a complete fixed burst at the same point that auto precharge would.

The block starts the row-precharge time when PRECHARGE issues, so part of that time passes while the last data beats are still arriving. The `ready_o` output returns as soon as the next ACTIVE may follow. A `rd_valid_o` strobe marks the cycles in which read data is present on the device pins. That strobe follows the configured CAS latency.

Configuration is sampled when a request is accepted, and it holds for that request and its data tail.

Top module: `sdr_early_pre_seq`

## Requirements
- R1: During and right after reset, `cmd_o` is NOP, `rd_valid_o` is low and `ready_o` is high.
- R2: Command codes are NOP=0, ACTIVE=1, READ=2, PRECHARGE=3. Every cycle that has no scheduled command carries NOP, and each accepted request produces exactly three commands.
- R3: A request is accepted in a cycle where `req_valid_i` and `ready_o` are both high. ACTIVE appears on the next cycle with the request's bank and with the row on `addr_o`.
- R4: READ follows ACTIVE by exactly TRCD cycles, on the same bank, with the column in the low bits of `addr_o` and zeros above it.
- R5: Let L be the effective element count. PRECHARGE to the same bank appears exactly L cycles after READ, which is CAS latency minus one cycles before the last wanted element. For four elements it comes 4 cycles after READ at both CAS latencies.
- R6: A requested count of 0 is treated as 1, so PRECHARGE comes on the cycle right after READ.
- R7: In fixed mode (`cfg_full_page_i`=0), `cfg_bl_i`=c gives a burst length of 2^c and L=min(count, 2^c). A complete burst ends with PRECHARGE exactly burst-length cycles after READ.
- R8: In full-page mode, L=min(count, 2^COL_W).
- R9: `cfg_cl3_i`=0 selects CAS latency 2 and 1 selects CAS latency 3. `rd_valid_o` goes high CAS-latency cycles after READ and stays high for exactly L cycles.
- R10: After PRECHARGE, `ready_o` stays low for max(tRP,1)−1 cycles, so the next ACTIVE comes no earlier than max(tRP,1) cycles after PRECHARGE. A tRP of 0 acts as 1.
- R11: A request presented while `ready_o` is low is ignored and produces no command.
- R12: When L ≥ CAS latency, `rd_valid_o` is high in the PRECHARGE cycle, so data transfer and precharge overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_bank_i | input | BANK_W | Bank of the request |
| req_row_i | input | ROW_W | Row to open |
| req_col_i | input | COL_W | Starting column |
| req_len_i | input | LEN_W | Wanted element count |
| cfg_cl3_i | input | 1 | 0: CAS latency 2, 1: CAS latency 3 |
| cfg_bl_i | input | 2 | Fixed burst length code, length 2^code |
| cfg_full_page_i | input | 1 | Full-page burst mode |
| cfg_trp_i | input | TRP_W | Row-precharge time in cycles |
| ready_o | output | 1 | Request may be accepted |
| cmd_o | output | 2 | Command code |
| bank_o | output | BANK_W | Bank of the command |
| addr_o | output | ADDR_W | Row or column address |
| rd_valid_o | output | 1 | Read data present on the device pins |

## Verification
Two events can land in the same cycle, and the bench provokes both.

The first is PRECHARGE issuing while read beats are still arriving. The bench runs vectors with counts at or above the CAS latency and checks that `rd_valid_o` is high in the PRECHARGE cycle. It runs vectors with shorter counts and checks that the strobe is low there.

The second is the ready return coinciding with the PRECHARGE cycle itself, when tRP is 0 or 1. The bench holds `req_valid_i` high through a whole transaction and checks that the next ACTIVE follows PRECHARGE by exactly one cycle. It also checks that requests held during a long precharge window produce no command.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_BURST = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sdr_len_calc.sv
module sdr_len_calc #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LEN_W = COL_W + 1
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       bl_code_i,
  input  logic             full_page_i,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned PAGE = 1 << COL_W;

  logic [LEN_W-1:0] len_nz, bl_val, cap;

  always_comb begin
    len_nz = (len_i == '0) ? LEN_W'(1) : len_i;
    bl_val = LEN_W'(1) << bl_code_i;
    cap    = full_page_i ? LEN_W'(PAGE) : bl_val;
    len_o  = (len_nz > cap) ? cap : len_nz;
  end
endmodule

// File: rtl/sdr_rp_timer.sv
module sdr_rp_timer #(
  parameter int unsigned TRP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TRP_W-1:0] trp_i,
  output logic             zero_o
);
  logic [TRP_W-1:0] cnt_q;
  logic [TRP_W-1:0] trp_eff;

  assign trp_eff = (trp_i == '0) ? TRP_W'(1) : trp_i;

  // loaded one edge before PRECHARGE shows, so the count reads tRP-1 in that cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= trp_eff - TRP_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - TRP_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  p_count_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(load_i) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - TRP_W'(1)));
endmodule

// File: rtl/sdr_rd_valid_pipe.sv
module sdr_rd_valid_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  input  logic cl3_i,
  output logic valid_o
);
  localparam int unsigned CL_MAX = 3;

  logic [CL_MAX-1:0] beat_sr;
  logic [CL_MAX-1:0] cl3_sr;

  // each beat carries its own latency tag so a later config change cannot cut the tail
  for (genvar g = 0; g < CL_MAX; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          beat_sr[0] <= 1'b0;
          cl3_sr[0]  <= 1'b0;
        end else begin
          beat_sr[0] <= beat_i;
          cl3_sr[0]  <= cl3_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          beat_sr[g] <= 1'b0;
          cl3_sr[g]  <= 1'b0;
        end else begin
          beat_sr[g] <= beat_sr[g-1];
          cl3_sr[g]  <= cl3_sr[g-1];
        end
      end
    end
  end

  assign valid_o = (beat_sr[1] & ~cl3_sr[1]) | (beat_sr[2] & cl3_sr[2]);

  p_valid_from_beat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(beat_i, 2) || $past(beat_i, 3)));
endmodule

// File: rtl/sdr_rd_ctrl.sv
module sdr_rd_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned LEN_W  = COL_W + 1,
  parameter int unsigned TRP_W  = 4,
  parameter int unsigned TRCD   = 2,
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              cl3_i,
  input  logic [TRP_W-1:0]  trp_i,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              beat_o,
  output logic              cl3_o,
  output logic [TRP_W-1:0]  trp_o,
  output logic              pre_load_o,
  output logic              idle_o
);
  seq_state_e        state_q, state_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  sdr_cmd_e          cmd_q, cmd_d;
  logic [BANK_W-1:0] bank_q, bank_d, req_bank_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [COL_W-1:0]  col_q;
  logic [LEN_W-1:0]  len_q;
  logic              cl3_q;
  logic [TRP_W-1:0]  trp_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cmd_d      = CMD_NOP;
    bank_d     = '0;
    addr_d     = '0;
    pre_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_i) begin
          cmd_d   = CMD_ACT;
          bank_d  = bank_i;
          addr_d  = ADDR_W'(row_i);
          cnt_d   = LEN_W'(TRCD - 1);
          state_d = ST_ACT;
        end
      end
      ST_ACT: begin
        if (cnt_q == '0) begin
          cmd_d   = CMD_RD;
          bank_d  = req_bank_q;
          addr_d  = ADDR_W'(col_q);
          // PRECHARGE lands len cycles after READ: CL-1 before the last wanted beat
          cnt_d   = len_q - LEN_W'(1);
          state_d = ST_BURST;
        end else begin
          cnt_d = cnt_q - LEN_W'(1);
        end
      end
      ST_BURST: begin
        if (cnt_q == '0) begin
          cmd_d      = CMD_PRE;
          bank_d     = req_bank_q;
          pre_load_o = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          cnt_d = cnt_q - LEN_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= CMD_NOP;
      bank_q  <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      bank_q  <= bank_d;
      addr_q  <= addr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_bank_q <= '0;
      col_q      <= '0;
      len_q      <= LEN_W'(1);
      cl3_q      <= 1'b0;
      trp_q      <= '0;
    end else if (accept_i && state_q == ST_IDLE) begin
      req_bank_q <= bank_i;
      col_q      <= col_i;
      len_q      <= len_i;
      cl3_q      <= cl3_i;
      trp_q      <= trp_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign bank_o = bank_q;
  assign addr_o = addr_q;
  assign beat_o = (state_q == ST_BURST);
  assign cl3_o  = cl3_q;
  assign trp_o  = trp_q;
  assign idle_o = (state_q == ST_IDLE);

  p_read_after_act_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD) |-> ($past(state_q) == ST_ACT));
  p_pre_ends_burst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> ($past(state_q) == ST_BURST && bank_q == req_bank_q));
endmodule

// File: rtl/sdr_early_pre_seq.sv
module sdr_early_pre_seq
  import sdr_seq_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned LEN_W  = COL_W + 1,
  parameter int unsigned TRP_W  = 4,
  parameter int unsigned TRCD   = 2,
  localparam int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              cfg_cl3_i,
  input  logic [1:0]        cfg_bl_i,
  input  logic              cfg_full_page_i,
  input  logic [TRP_W-1:0]  cfg_trp_i,
  output logic              ready_o,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_valid_o
);
  logic [LEN_W-1:0] len_eff;
  logic             accept, idle, rp_zero, beat, cl3_lat, pre_load;
  logic [TRP_W-1:0] trp_lat;

  assign ready_o = idle & rp_zero;
  assign accept  = req_valid_i & ready_o;

  sdr_len_calc #(.COL_W(COL_W), .LEN_W(LEN_W)) i_len_calc (
    .len_i       (req_len_i),
    .bl_code_i   (cfg_bl_i),
    .full_page_i (cfg_full_page_i),
    .len_o       (len_eff)
  );

  sdr_rd_ctrl #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .LEN_W(LEN_W), .TRP_W(TRP_W), .TRCD(TRCD)
  ) i_rd_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .bank_i     (req_bank_i),
    .row_i      (req_row_i),
    .col_i      (req_col_i),
    .len_i      (len_eff),
    .cl3_i      (cfg_cl3_i),
    .trp_i      (cfg_trp_i),
    .cmd_o      (cmd_o),
    .bank_o     (bank_o),
    .addr_o     (addr_o),
    .beat_o     (beat),
    .cl3_o      (cl3_lat),
    .trp_o      (trp_lat),
    .pre_load_o (pre_load),
    .idle_o     (idle)
  );

  sdr_rp_timer #(.TRP_W(TRP_W)) i_rp_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pre_load),
    .trp_i  (trp_lat),
    .zero_o (rp_zero)
  );

  sdr_rd_valid_pipe i_valid_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .beat_i  (beat),
    .cl3_i   (cl3_lat),
    .valid_o (rd_valid_o)
  );

  p_act_on_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> $past(req_valid_i && ready_o));
  p_act_after_rp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> $past(rp_zero));
  p_nop_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ready_o && !req_valid_i) |-> (cmd_o == CMD_NOP));
  p_busy_ignores_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ready_o && idle) |-> (cmd_o != CMD_ACT));
endmodule

// File: tb/test_sdr_early_pre_seq.sv
module test_sdr_early_pre_seq;
  import sdr_seq_pkg::*;

  localparam int BANK_W = 2;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 8;
  localparam int LEN_W  = 9;
  localparam int TRP_W  = 4;
  localparam int TRCD   = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [BANK_W-1:0] req_bank_i = '0;
  logic [ROW_W-1:0]  req_row_i = '0;
  logic [COL_W-1:0]  req_col_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic              cfg_cl3_i = 1'b0;
  logic [1:0]        cfg_bl_i = '0;
  logic              cfg_full_page_i = 1'b0;
  logic [TRP_W-1:0]  cfg_trp_i = '0;
  logic              ready_o;
  logic [1:0]        cmd_o;
  logic [BANK_W-1:0] bank_o;
  logic [ROW_W-1:0]  addr_o;
  logic              rd_valid_o;

  sdr_early_pre_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .LEN_W(LEN_W), .TRP_W(TRP_W), .TRCD(TRCD)
  ) i_sdr_early_pre_seq (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       cl3;
    logic [1:0] bl;
    logic       fp;
    int         len;
    int         trp;
    int         off;
    int         beats;
    int         gap;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 1'b0,   4, 3,   4,   4, 2},  // R5 burst of four, CL2
    '{1'b1, 2'd2, 1'b0,   4, 3,   4,   4, 2},  // R5 burst of four, CL3
    '{1'b0, 2'd3, 1'b0,   3, 2,   3,   3, 1},  // R7 truncated fixed burst
    '{1'b1, 2'd1, 1'b0,   6, 1,   2,   2, 0},  // R7 count clipped to burst
    '{1'b1, 2'd0, 1'b1,  20, 4,  20,  20, 3},  // R8 full page
    '{1'b0, 2'd2, 1'b0,   0, 0,   1,   1, 0},  // R6 zero count, tRP 0
    '{1'b1, 2'd0, 1'b0,   1, 5,   1,   1, 4},  // R6 single beat CL3
    '{1'b0, 2'd1, 1'b1, 256, 2, 256, 256, 1}   // R8 whole page
  };

  task automatic run_txn(input vec_t v, input int row, input int col, input int bank,
                         output int r_act, output int r_rd, output int r_pre,
                         output int r_v0, output int r_nb, output int r_rdy,
                         output int r_cmds, output int r_act_addr, output int r_rd_addr,
                         output int r_bank_ok, output int r_vpre);
    @(negedge clk_i);
    cfg_cl3_i       = v.cl3;
    cfg_bl_i        = v.bl;
    cfg_full_page_i = v.fp;
    cfg_trp_i       = TRP_W'(v.trp);
    req_len_i       = LEN_W'(v.len);
    req_row_i       = ROW_W'(row);
    req_col_i       = COL_W'(col);
    req_bank_i      = BANK_W'(bank);
    while (!ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    r_act = -1; r_rd = -1; r_pre = -1; r_v0 = -1; r_nb = 0; r_rdy = -1;
    r_cmds = 0; r_act_addr = -1; r_rd_addr = -1; r_bank_ok = 1; r_vpre = -1;
    for (int i = 0; i < v.len + 40; i++) begin
      if (cmd_o != CMD_NOP) begin
        r_cmds++;
        if (int'(bank_o) != bank) r_bank_ok = 0;
      end
      if (cmd_o == CMD_ACT && r_act < 0) begin
        r_act = i; r_act_addr = int'(addr_o);
      end
      if (cmd_o == CMD_RD && r_rd < 0) begin
        r_rd = i; r_rd_addr = int'(addr_o);
      end
      if (cmd_o == CMD_PRE && r_pre < 0) begin
        r_pre = i; r_vpre = int'(rd_valid_o);
      end
      if (rd_valid_o) begin
        r_nb++;
        if (r_v0 < 0) r_v0 = i;
      end
      if (r_pre >= 0 && r_rdy < 0 && ready_o) r_rdy = i;
      @(negedge clk_i);
    end
  endtask

  initial begin
    int a, rd, pr, v0, nb, rdy, nc, aa, ra, bok, vp;
    int cl, p_at, act_cnt, rise, first_pre, next_act;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 cmd in reset", int'(cmd_o), 0);
    chk("R1 valid in reset", int'(rd_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after reset", int'(ready_o), 1);
    chk("R1 cmd after reset", int'(cmd_o), 0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v  = VECS[k];
      cl = v.cl3 ? 3 : 2;
      run_txn(v, 100 + 37 * k, 3 * k + 1, k % 4, a, rd, pr, v0, nb, rdy, nc, aa, ra, bok, vp);
      chk("R3 ACTIVE slot", a, 0);
      chk("R3 ACTIVE row", aa, 100 + 37 * k);
      chk("R3 bank on all commands", bok, 1);
      chk("R4 READ delay", rd - a, TRCD);
      chk("R4 READ column", ra, 3 * k + 1);
      chk("R5 R6 R7 R8 PRECHARGE offset", pr - rd, v.off);
      chk("R9 first valid latency", v0 - rd, cl);
      chk("R9 valid beat count", nb, v.beats);
      chk("R10 ready gap after PRECHARGE", rdy - pr, v.gap);
      chk("R2 command count", nc, 3);
      chk("R12 valid during PRECHARGE", vp, (v.off >= cl) ? 1 : 0);
    end

    // R11 requests in the precharge window are dropped; R10 long window
    @(negedge clk_i);
    cfg_cl3_i = 1'b0; cfg_bl_i = 2'd0; cfg_full_page_i = 1'b0;
    cfg_trp_i = TRP_W'(8); req_len_i = LEN_W'(1); req_row_i = ROW_W'(5);
    req_col_i = '0; req_bank_i = '0;
    while (!ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    p_at = 0;
    while (cmd_o != CMD_PRE && p_at < 20) begin
      @(negedge clk_i);
      p_at++;
    end
    req_row_i = ROW_W'(777);
    act_cnt = 0;
    rise = -1;
    for (int i = 0; i < 11; i++) begin
      if (cmd_o == CMD_ACT) act_cnt++;
      if (ready_o && rise < 0) rise = i;
      if (i == 0) req_valid_i = 1'b1;
      if (i == 2) req_valid_i = 1'b0;
      @(negedge clk_i);
    end
    chk("R11 no ACTIVE from busy request", act_cnt, 0);
    chk("R10 ready return tRP 8", rise, 7);

    // R10 back to back with tRP 1: ready returns in the PRECHARGE cycle
    cfg_trp_i = TRP_W'(1); cfg_bl_i = 2'd1; req_len_i = LEN_W'(2);
    while (!ready_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    first_pre = -1;
    next_act = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (cmd_o == CMD_PRE && first_pre < 0) begin
        first_pre = i;
        chk("R10 ready in PRECHARGE cycle", int'(ready_o), 1);
      end
      if (cmd_o == CMD_ACT && first_pre >= 0 && next_act < 0) next_act = i;
    end
    req_valid_i = 1'b0;
    chk("R10 back to back ACTIVE gap", next_act - first_pre, 1);

    repeat (20) @(negedge clk_i);
    chk("R2 idle bus NOP", int'(cmd_o), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule